// File: doc/BRIEF.md
# Serial Management Register Agent

This block is the transceiver-side end of a two-wire management bus. It watches the management clock and data lines and rebuilds clause 22 read and write frames bit by bit. On a read it takes over the data line at the right moment and shifts out the register contents. On a write it updates the control fields that the rest of the transceiver uses. The block runs on a fast system clock. It resynchronises both bus lines and acts on each rising edge of the management clock. Its data output and output enable are registered, so the line changes a few system cycles after that rising edge.

The station address comes from three strap inputs. It is captured while reset is asserted and then held until the next reset. Address 0 is also accepted, which lets one write reach every agent on the bus.

The register file covers the following:
- a control word, with one self-clearing restart bit;
- a read-only status word;
- two identifier words;
- a cable-fault distance word;
- a word that encodes the resolved link mode.

Every register value that is not control state comes from an input port, because negotiation, cable testing and link detection are all outside the block.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: The station address is {2'b00, strap_addr}, captured while rst_n is low and held until the next reset. Later strap changes have no effect, and an address with bit 4 or bit 3 set never matches a nonzero strap.
- R2: Address 0 is accepted for both reads and writes, in addition to the strapped address.
- R3: A frame whose address is neither the station address nor 0 leaves the data line undriven and changes no register.
- R4: On a matching read, the data line stays released during the first turnaround bit. It is driven 0 during the second turnaround bit, then carries the 16 register bits MSB first, and is released after the last bit.
- R5: A write to register 0 loads the following fields from 16 bits sent MSB first: bit 13 speed-100, bit 12 negotiation enable, bit 11 power-down (1 = powered down), bit 10 isolate (1 = isolated) and bit 8 full duplex. After reset these fields read 1,1,0,0,1, and the same fields read back in the same bit positions.
- R6: Writing 1 to register 0 bit 9 makes an_restart high for exactly one system cycle. Bit 9 always reads back 0.
- R7: Register 1Fh bits [4:2] give the mode code: 000 while negotiation is not done, 001 for 10 half, 010 for 100 half, 101 for 10 full and 110 for 100 full. All other bits of the register read 0.
- R8: The status and identifier registers read as follows:
  - Register 1 reads {5'b11000, 5'b0, an_done, 0, 1, link_up, 0, 1}.
  - Register 2 reads 16'h0022.
  - Register 3 reads {6'h05 identifier bits, 6'h11 model, 4'h2 revision}.
- R9: Register 1Dh reads {7'b0, fault_dist} and follows the input.
- R10: Writes to registers other than 0 are ignored. Reads of registers other than 0, 1, 2, 3, 1Dh and 1Fh return 0.
- R11: A frame is accepted only after at least 32 consecutive ones followed by start bits 0,1. Opcode 10 selects a read and 01 a write. Any other opcode, or a preamble that is too short, aborts the frame without driving the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; straps are captured while low |
| strap_addr | input | 3 | Low station-address bits from straps |
| mdc | input | 1 | Management clock from the bus master |
| mdio_in | input | 1 | Management data line as received |
| mdio_out | output | 1 | Data value to drive onto the line |
| mdio_oe | output | 1 | Enable for the line driver |
| an_done | input | 1 | Negotiation finished |
| link_up | input | 1 | Link is established |
| res_100 | input | 1 | Resolved speed is 100 |
| res_full | input | 1 | Resolved duplex is full |
| fault_dist | input | 9 | Cable-fault distance count |
| ctl_speed100 | output | 1 | Control: speed-100 select |
| ctl_an_en | output | 1 | Control: negotiation enable |
| ctl_pdown | output | 1 | Control: power-down |
| ctl_iso | output | 1 | Control: isolate |
| ctl_full | output | 1 | Control: full-duplex select |
| an_restart | output | 1 | One-cycle negotiation restart pulse |

## Verification
The assertions check the following on every cycle:
- the address latch never moves after reset and never has bits 4 or 3 set;
- the line driver only switches in the cycle after a management-clock rising edge;
- every driven stretch starts with a 0;
- the restart pulse lasts one cycle;
- the isolate and power-down fields only change after a write strobe.

Only the bench scenarios can show which values are returned. These include:
- the mode encodings and identifier contents;
- rejection of foreign addresses, short preambles and bad opcodes;
- the broadcast path;
- the fact that writes to read-only locations leave their contents unchanged.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_OP,
        FR_ADDR,
        FR_TA,
        FR_DATA
    } fr_state_e;

    localparam logic [4:0] RA_CTRL  = 5'h00;
    localparam logic [4:0] RA_STAT  = 5'h01;
    localparam logic [4:0] RA_ID1   = 5'h02;
    localparam logic [4:0] RA_ID2   = 5'h03;
    localparam logic [4:0] RA_CABLE = 5'h1D;
    localparam logic [4:0] RA_MODE  = 5'h1F;

    typedef struct packed {
        logic speed100;
        logic an_en;
        logic pdown;
        logic iso;
        logic full;
    } ctl_t;

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_raw,
    input  logic mdio_raw,
    output logic rise,
    output logic bit_val
);
    typedef struct packed {
        logic [STAGES-1:0] mdc_sh;
        logic [STAGES-1:0] dat_sh;
        logic              mdc_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.mdc_sh   = {s_q.mdc_sh[STAGES-2:0], mdc_raw};
        s_d.dat_sh   = {s_q.dat_sh[STAGES-2:0], mdio_raw};
        s_d.mdc_prev = s_q.mdc_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mdc_sh   <= '0;
            s_q.dat_sh   <= '1;
            s_q.mdc_prev <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise    = s_q.mdc_sh[STAGES-1] & ~s_q.mdc_prev;
    assign bit_val = s_q.dat_sh[STAGES-1];
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_MIN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rise,
    input  logic        bit_in,
    input  logic [4:0]  my_addr,
    input  logic [15:0] rd_data,
    output logic [4:0]  rd_addr,
    output logic        wr_stb,
    output logic [4:0]  wr_addr,
    output logic [15:0] wr_data,
    output logic        mdio_out,
    output logic        mdio_oe
);
    localparam int ONE_W = $clog2(PRE_MIN + 1);
    localparam logic [ONE_W-1:0] ONE_FULL = ONE_W'(PRE_MIN);

    typedef struct packed {
        fr_state_e        st;
        logic [ONE_W-1:0] ones;
        logic [4:0]       cnt;
        logic             is_rd;
        logic [9:0]       addr;
        logic [15:0]      sh;
        logic             out;
        logic             oe;
        logic             wr;
    } fr_t;

    fr_t f_d, f_q;
    logic [9:0]  addr_n;
    logic        hit;
    logic [15:0] sh_n;

    assign addr_n  = {f_q.addr[8:0], bit_in};
    assign hit     = (addr_n[9:5] == my_addr) || (addr_n[9:5] == 5'd0);
    assign rd_addr = addr_n[4:0];
    assign sh_n    = {f_q.sh[14:0], f_q.is_rd ? 1'b0 : bit_in};

    always_comb begin
        f_d    = f_q;
        f_d.wr = 1'b0;
        if (rise) begin
            case (f_q.st)
                FR_IDLE: begin
                    if (bit_in) begin
                        if (f_q.ones != ONE_FULL) f_d.ones = f_q.ones + 1'b1;
                    end else begin
                        if (f_q.ones == ONE_FULL) f_d.st = FR_START;
                        f_d.ones = '0;
                    end
                end
                FR_START: begin
                    f_d.st  = bit_in ? FR_OP : FR_IDLE;
                    f_d.cnt = '0;
                end
                FR_OP: begin
                    if (f_q.cnt == 5'd0) begin
                        f_d.is_rd = bit_in;
                        f_d.cnt   = 5'd1;
                    end else if (bit_in == f_q.is_rd) begin
                        f_d.st = FR_IDLE;
                    end else begin
                        f_d.st  = FR_ADDR;
                        f_d.cnt = '0;
                    end
                end
                FR_ADDR: begin
                    f_d.addr = addr_n;
                    if (f_q.cnt == 5'd9) begin
                        f_d.cnt = '0;
                        if (!hit) begin
                            f_d.st = FR_IDLE;
                        end else begin
                            f_d.st = FR_TA;
                            if (f_q.is_rd) f_d.sh = rd_data;
                        end
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                FR_TA: begin
                    if (f_q.cnt == 5'd0) begin
                        f_d.cnt = 5'd1;
                        if (f_q.is_rd) begin
                            f_d.oe  = 1'b1;
                            f_d.out = 1'b0;
                        end
                    end else begin
                        f_d.st  = FR_DATA;
                        f_d.cnt = '0;
                        if (f_q.is_rd) f_d.out = f_q.sh[15];
                    end
                end
                FR_DATA: begin
                    if (f_q.cnt == 5'd15) begin
                        f_d.st = FR_IDLE;
                        f_d.oe = 1'b0;
                        if (!f_q.is_rd) begin
                            f_d.sh = sh_n;
                            f_d.wr = 1'b1;
                        end
                    end else begin
                        f_d.sh  = sh_n;
                        f_d.out = sh_n[15];
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                default: f_d.st = FR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st    <= FR_IDLE;
            f_q.ones  <= '0;
            f_q.cnt   <= '0;
            f_q.is_rd <= 1'b0;
            f_q.addr  <= '0;
            f_q.sh    <= '0;
            f_q.out   <= 1'b0;
            f_q.oe    <= 1'b0;
            f_q.wr    <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign wr_stb   = f_q.wr;
    assign wr_addr  = f_q.addr[4:0];
    assign wr_data  = f_q.sh;
    assign mdio_out = f_q.out;
    assign mdio_oe  = f_q.oe;
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_mgmt_pkg::*;
#(
    parameter int          DIST_W    = 9,
    parameter logic        AN_EN_RST = 1'b1,
    parameter logic [15:0] ID_HI     = 16'h0022,
    parameter logic [5:0]  OUI_LO    = 6'h05,
    parameter logic [5:0]  MODEL_NO  = 6'h11,
    parameter logic [3:0]  REV_NO    = 4'h2,
    parameter logic [4:0]  STAT_CAPS = 5'b11000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [4:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [4:0]        rd_addr,
    input  logic              an_done,
    input  logic              link_up,
    input  logic              res_100,
    input  logic              res_full,
    input  logic [DIST_W-1:0] fault_dist,
    output logic [15:0]       rd_data,
    output ctl_t              ctl,
    output logic              restart
);
    typedef struct packed {
        ctl_t ctl;
        logic restart;
    } rf_t;

    rf_t  r_d, r_q;
    logic [2:0] mode_code;
    logic unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[15:14], wr_data[7:0]};

    always_comb begin
        r_d         = r_q;
        r_d.restart = 1'b0;
        if (wr_stb && wr_addr == RA_CTRL) begin
            r_d.ctl.speed100 = wr_data[13];
            r_d.ctl.an_en    = wr_data[12];
            r_d.ctl.pdown    = wr_data[11];
            r_d.ctl.iso      = wr_data[10];
            r_d.ctl.full     = wr_data[8];
            r_d.restart      = wr_data[9];
        end
    end

    always_comb begin
        mode_code = an_done ? {res_full, res_100, ~res_100} : 3'b000;
        case (rd_addr)
            RA_CTRL:  rd_data = {1'b0, r_q.ctl.speed100, r_q.ctl.an_en, r_q.ctl.pdown,
                                 r_q.ctl.iso, 1'b0, r_q.ctl.full, 8'h00};
            RA_STAT:  rd_data = {STAT_CAPS, 5'b0, an_done, 1'b0, 1'b1, link_up, 1'b0, 1'b1};
            RA_ID1:   rd_data = ID_HI;
            RA_ID2:   rd_data = {OUI_LO, MODEL_NO, REV_NO};
            RA_CABLE: rd_data = {{(16-DIST_W){1'b0}}, fault_dist};
            RA_MODE:  rd_data = {11'b0, mode_code, 2'b00};
            default:  rd_data = 16'h0000;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctl.speed100 <= 1'b1;
            r_q.ctl.an_en    <= AN_EN_RST;
            r_q.ctl.pdown    <= 1'b0;
            r_q.ctl.iso      <= 1'b0;
            r_q.ctl.full     <= 1'b1;
            r_q.restart      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl     = r_q.ctl;
    assign restart = r_q.restart;
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
    import mdio_mgmt_pkg::*;
#(
    parameter int          PRE_MIN     = 32,
    parameter int          SYNC_STAGES = 2,
    parameter int          STRAP_W     = 3,
    parameter int          DIST_W      = 9,
    parameter logic        AN_EN_RST   = 1'b1,
    parameter logic [15:0] ID_HI       = 16'h0022,
    parameter logic [5:0]  OUI_LO      = 6'h05,
    parameter logic [5:0]  MODEL_NO    = 6'h11,
    parameter logic [3:0]  REV_NO      = 4'h2,
    parameter logic [4:0]  STAT_CAPS   = 5'b11000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic               mdc,
    input  logic               mdio_in,
    output logic               mdio_out,
    output logic               mdio_oe,
    input  logic               an_done,
    input  logic               link_up,
    input  logic               res_100,
    input  logic               res_full,
    input  logic [DIST_W-1:0]  fault_dist,
    output logic               ctl_speed100,
    output logic               ctl_an_en,
    output logic               ctl_pdown,
    output logic               ctl_iso,
    output logic               ctl_full,
    output logic               an_restart
);
    logic [4:0]  phy_addr_d, phy_addr_q;
    logic        mdc_rise, bit_val, wr_stb;
    logic [4:0]  rd_addr, wr_addr;
    logic [15:0] rd_data, wr_data;
    ctl_t        ctl;

    always_comb phy_addr_d = phy_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phy_addr_q <= {{(5-STRAP_W){1'b0}}, strap_addr};
        else        phy_addr_q <= phy_addr_d;
    end

    mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc_raw  (mdc),
        .mdio_raw (mdio_in),
        .rise     (mdc_rise),
        .bit_val  (bit_val)
    );

    mdio_frame_fsm #(.PRE_MIN(PRE_MIN)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (mdc_rise),
        .bit_in   (bit_val),
        .my_addr  (phy_addr_q),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

    mdio_regfile #(
        .DIST_W    (DIST_W),
        .AN_EN_RST (AN_EN_RST),
        .ID_HI     (ID_HI),
        .OUI_LO    (OUI_LO),
        .MODEL_NO  (MODEL_NO),
        .REV_NO    (REV_NO),
        .STAT_CAPS (STAT_CAPS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .an_done    (an_done),
        .link_up    (link_up),
        .res_100    (res_100),
        .res_full   (res_full),
        .fault_dist (fault_dist),
        .rd_data    (rd_data),
        .ctl        (ctl),
        .restart    (an_restart)
    );

    assign ctl_speed100 = ctl.speed100;
    assign ctl_an_en    = ctl.an_en;
    assign ctl_pdown    = ctl.pdown;
    assign ctl_iso      = ctl.iso;
    assign ctl_full     = ctl.full;
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mdc_rise,
    input logic       wr_stb,
    input logic       mdio_oe,
    input logic       mdio_out,
    input logic       an_restart,
    input logic       ctl_iso,
    input logic       ctl_pdown,
    input logic [4:0] phy_addr
);
    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(phy_addr) && phy_addr[4:3] == 2'b00);

    assert_oe_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> $past(mdc_rise));

    assert_ta_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);

    assert_restart_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart |=> !an_restart);

    assert_ctl_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ctl_iso) || !$stable(ctl_pdown)) |-> $past(wr_stb));
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mdc_rise   (mdc_rise),
    .wr_stb     (wr_stb),
    .mdio_oe    (mdio_oe),
    .mdio_out   (mdio_out),
    .an_restart (an_restart),
    .ctl_iso    (ctl_iso),
    .ctl_pdown  (ctl_pdown),
    .phy_addr   (phy_addr_q)
);

// File: tb/tb_mdio_mgmt_slave.sv
module tb_mdio_mgmt_slave;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] strap_addr = 3'b101;
    logic       mdc = 1'b0;
    logic       mdio_in = 1'b1;
    logic       mdio_out, mdio_oe;
    logic       an_done = 1'b0, link_up = 1'b0, res_100 = 1'b0, res_full = 1'b0;
    logic [8:0] fault_dist = 9'd0;
    logic       ctl_speed100, ctl_an_en, ctl_pdown, ctl_iso, ctl_full, an_restart;

    int checks = 0;
    int failures = 0;
    int pulse_cnt = 0;
    bit done = 0;

    // model state
    logic [4:0] m_addr;
    logic m_speed, m_an, m_pd, m_iso, m_full;

    always #2 clk = ~clk;

    mdio_mgmt_slave dut (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .mdc(mdc), .mdio_in(mdio_in),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .an_done(an_done), .link_up(link_up),
        .res_100(res_100), .res_full(res_full), .fault_dist(fault_dist),
        .ctl_speed100(ctl_speed100), .ctl_an_en(ctl_an_en), .ctl_pdown(ctl_pdown),
        .ctl_iso(ctl_iso), .ctl_full(ctl_full), .an_restart(an_restart)
    );

    always @(negedge clk) if (rst_n && an_restart) pulse_cnt++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_reg(input logic [4:0] ra);
        logic [2:0] md;
        if (!an_done) md = 3'd0;
        else if (!res_full && !res_100) md = 3'd1;
        else if (!res_full && res_100) md = 3'd2;
        else if (res_full && !res_100) md = 3'd5;
        else md = 3'd6;
        case (ra)
            5'h00: return {1'b0, m_speed, m_an, m_pd, m_iso, 1'b0, m_full, 8'h00};
            5'h01: return {5'b11000, 5'b0, an_done, 1'b0, 1'b1, link_up, 1'b0, 1'b1};
            5'h02: return 16'h0022;
            5'h03: return {6'h05, 6'h11, 4'h2};
            5'h1D: return {7'b0, fault_dist};
            5'h1F: return {11'b0, md, 2'b00};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic bit responds(input logic [4:0] phy);
        return (phy == m_addr) || (phy == 5'd0);
    endfunction

    task automatic model_reset();
        m_addr = {2'b00, strap_addr};
        m_speed = 1; m_an = 1; m_pd = 0; m_iso = 0; m_full = 1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // one management clock period; samples what the agent drives in this bit
    task automatic xfer(input logic b, output logic so, output logic soe);
        mdio_in = b;
        repeat (HALF) @(negedge clk);
        so  = mdio_out;
        soe = mdio_oe;
        mdc = 1'b1;
        repeat (HALF) @(negedge clk);
        mdc = 1'b0;
    endtask

    // full frame; per-bit comparison of the line against the model
    task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] ra, input logic [15:0] wdata,
                         input bit drive, input logic [15:0] edata, input string req,
                         output logic [15:0] got);
        logic so, soe;
        int bad = 0;
        logic [15:0] exp_seen;
        bit is_rd = (op == 2'b10);
        got = 16'h0;
        exp_seen = edata;
        xfer(1'b0, so, soe); if (soe) bad++;
        for (int i = 0; i < pre; i++) begin xfer(1'b1, so, soe); if (soe) bad++; end
        xfer(1'b0, so, soe); if (soe) bad++;
        xfer(1'b1, so, soe); if (soe) bad++;
        xfer(op[1], so, soe); if (soe) bad++;
        xfer(op[0], so, soe); if (soe) bad++;
        for (int i = 4; i >= 0; i--) begin xfer(phy[i], so, soe); if (soe) bad++; end
        for (int i = 4; i >= 0; i--) begin xfer(ra[i], so, soe); if (soe) bad++; end
        xfer(1'b1, so, soe); if (soe) bad++;
        xfer(is_rd ? 1'b1 : 1'b0, so, soe);
        if (soe !== drive || (drive && so !== 1'b0)) bad++;
        for (int i = 15; i >= 0; i--) begin
            xfer(is_rd ? 1'b1 : wdata[i], so, soe);
            got[i] = so;
            if (soe !== drive || (drive && so !== edata[i])) bad++;
        end
        xfer(1'b1, so, soe); if (soe) bad++;
        xfer(1'b1, so, soe); if (soe) bad++;
        if (!drive) got = 16'h0;
        chk(bad == 0, req, $sformatf("frame phy=%h reg=%h line errors=%0d", phy, ra, bad),
            {16'h0, got}, {16'h0, drive ? exp_seen : 16'h0});
    endtask

    task automatic rd(input logic [4:0] phy, input logic [4:0] ra, input string req);
        logic [15:0] g;
        bit dr = responds(phy);
        frame(32, 2'b10, phy, ra, 16'h0, dr, exp_reg(ra), req, g);
    endtask

    task automatic wr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d,
                      input string req);
        logic [15:0] g;
        frame(32, 2'b01, phy, ra, d, 1'b0, 16'h0, req, g);
        if (responds(phy) && ra == 5'h00) begin
            m_speed = d[13]; m_an = d[12]; m_pd = d[11]; m_iso = d[10]; m_full = d[8];
        end
    endtask

    task automatic chk_ctl(input string req);
        chk({ctl_speed100, ctl_an_en, ctl_pdown, ctl_iso, ctl_full} ===
            {m_speed, m_an, m_pd, m_iso, m_full}, req, "control outputs",
            {27'h0, ctl_speed100, ctl_an_en, ctl_pdown, ctl_iso, ctl_full},
            {27'h0, m_speed, m_an, m_pd, m_iso, m_full});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] g;
        do_reset();
        // R5 reset values, line idle
        chk_ctl("R5");
        chk(mdio_oe === 1'b0 && an_restart === 1'b0, "R4", "idle line and pulse",
            {30'h0, mdio_oe, an_restart}, 32'h0);

        // R1 R4 read at strapped address
        rd(5'd5, 5'h00, "R1");
        // R8 status and identifiers
        link_up = 1; an_done = 1;
        rd(5'd5, 5'h01, "R8");
        rd(5'd5, 5'h02, "R8");
        rd(5'd5, 5'h03, "R8");
        // R9 cable fault distance
        fault_dist = 9'h1A5; rd(5'd5, 5'h1D, "R9");
        fault_dist = 9'h003; rd(5'd5, 5'h1D, "R9");
        // R7 mode encodings
        an_done = 0; rd(5'd5, 5'h1F, "R7");
        for (int k = 0; k < 4; k++) begin
            an_done = 1; res_full = k[1]; res_100 = k[0];
            rd(5'd5, 5'h1F, "R7");
        end

        // R5 write control fields
        wr(5'd5, 5'h00, 16'h0C00, "R5");
        chk_ctl("R5");
        rd(5'd5, 5'h00, "R5");

        // R6 restart self-clear
        pulse_cnt = 0;
        wr(5'd5, 5'h00, 16'h1200, "R6");
        chk(pulse_cnt == 1, "R6", "restart pulse cycles", pulse_cnt, 1);
        rd(5'd5, 5'h00, "R6");

        // R2 broadcast
        wr(5'd0, 5'h00, 16'h2100, "R2");
        chk_ctl("R2");
        rd(5'd0, 5'h03, "R2");

        // R3 foreign address
        rd(5'd6, 5'h00, "R3");
        wr(5'd6, 5'h00, 16'h0C00, "R3");
        chk_ctl("R3");
        rd(5'd5, 5'h00, "R3");

        // R10 read-only and unimplemented
        wr(5'd5, 5'h01, 16'hFFFF, "R10");
        wr(5'd5, 5'h05, 16'hFFFF, "R10");
        wr(5'd5, 5'h1F, 16'hFFFF, "R10");
        chk_ctl("R10");
        rd(5'd5, 5'h05, "R10");
        rd(5'd5, 5'h01, "R10");
        rd(5'd5, 5'h1F, "R10");

        // R11 framing rejection
        frame(31, 2'b10, 5'd5, 5'h02, 16'h0, 1'b0, 16'h0, "R11", g);
        frame(32, 2'b11, 5'd5, 5'h02, 16'h0, 1'b0, 16'h0, "R11", g);
        frame(32, 2'b00, 5'd5, 5'h00, 16'h0000, 1'b0, 16'h0, "R11", g);
        chk_ctl("R11");
        rd(5'd5, 5'h02, "R11");

        // R1 strap change without reset, then with reset
        strap_addr = 3'b011;
        rd(5'd5, 5'h02, "R1");
        rd(5'd3, 5'h02, "R1");
        do_reset();
        chk_ctl("R1");
        rd(5'd3, 5'h02, "R1");
        rd(5'd5, 5'h02, "R1");
        rd(5'h1B, 5'h02, "R1");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule